// File: doc/BRIEF.md
# Pipelined Piecewise-Linear Function Evaluator

This block maps an unsigned fixed-point argument onto a smooth, monotonic function by linear interpolation between stored knots. The upper bits of the argument choose a segment. A table built at elaboration supplies that segment's starting value and its rise across the segment. The lower bits then scale the rise. The scaled rise is rounded to nearest and added to the starting value. When the sum would not fit in the output width, the result clamps to the largest code. Its main use is the arctangent step that turns local slopes into global angles. The default table holds a concave curve of the same shape, f(x) = x·(2048 − x)/1024 over x in 0..1023. The knots of this curve are exact integers, so the interpolation error can be worked out exactly.

Data enters and leaves on valid/ready streams. An argument is accepted on a rising edge where `arg_valid` and `arg_ready` are both high. A result is consumed on a rising edge where `res_valid` and `res_ready` are both high. The four pipeline stages move together, and only when the output register is empty or is being consumed. Whenever `res_valid` is high and `res_ready` is low, the whole pipeline freezes: `arg_ready` drops and the presented result stays unchanged. The block never drops data and never duplicates it. A cycle without an accepted argument sends a bubble down the pipeline; bubbles are not squeezed out.

Top module: `plf_eval`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `res_valid` is 0. `arg_ready` is 1 on that first cycle.
- R2: The segment index is `arg_data[9:5]` (k) and the fraction is `arg_data[4:0]` (f). The result is min(1023, k·(64−k) + ((63−2k)·f + 16) >> 5): the segment base plus the slope times the fraction over 32, with halves rounded up.
- R3: Every result differs from the exact value x·(2048−x)/1024 by less than 1 output LSB, for every x from 0 to 1023.
- R4: When `res_ready` stays high, a result appears on `res_valid`/`res_data` exactly 4 clock edges after its argument is accepted.
- R5: With `res_ready` held high, `arg_ready` stays high and one argument can be accepted on every cycle. Results leave in the order the arguments were accepted.
- R6: The output saturates. For x from 1008 to 1023 the interpolated sum would reach 1024, and the result is 1023.
- R7: While `res_valid` is 1 and `res_ready` is 0, `arg_ready` is 0. On the next cycle `res_valid` is still 1 and `res_data` is unchanged. No accepted argument is lost.
- R8: At a knot (f = 0), the result equals the stored base k·(64−k) exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arg_valid | input | 1 | Argument present |
| arg_ready | output | 1 | Block can take an argument this cycle |
| arg_data | input | 10 | Unsigned argument: segment index in the upper bits, fraction in the lower bits |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 10 | Rounded, saturated function value |

## Verification
Two things can land in the same cycle: a saturating result reaching the output, and a downstream stall that freezes the pipeline. The bench feeds the top segment (x ≥ 1008) and the knots while `res_ready` follows a pseudo-random pattern. Each stall must then hold a clamped 1023 or an exact knot value stable. Each saturated value must also be delivered exactly once and in order. The scoreboard judges every delivered result against the rounding formula and against the exact curve, and it checks that each stalled output is the same on the following cycle.

// File: rtl/plf_pkg.sv
package plf_pkg;

  // Knot value of the default curve f(x) = x*(2M - x)/M, rescaled to the
  // output width, sampled at the start of segment k.
  function automatic longint knot_val(input int k, input int in_w,
                                      input int seg_w, input int out_w);
    longint m;
    longint x;
    longint num;
    m   = longint'(1) << in_w;
    x   = longint'(k) << (in_w - seg_w);
    num = x * (2 * m - x);
    return (num << out_w) >> (2 * in_w);
  endfunction

endpackage

// File: rtl/plf_seg_rom.sv
module plf_seg_rom #(
  parameter int IN_W    = 10,
  parameter int SEG_W   = 5,
  parameter int OUT_W   = 10,
  parameter int SLOPE_W = 7,
  localparam int FRAC_W = IN_W - SEG_W,
  localparam int SEGS   = 1 << SEG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               vld_i,
  input  logic [IN_W-1:0]    x_i,
  output logic               vld_o,
  output logic [OUT_W-1:0]   base_o,
  output logic [SLOPE_W-1:0] slope_o,
  output logic [FRAC_W-1:0]  frac_o
);
  logic [OUT_W-1:0]   base_tab  [SEGS];
  logic [SLOPE_W-1:0] slope_tab [SEGS];

  for (genvar k = 0; k < SEGS; k++) begin : g_tab
    localparam longint KLO = plf_pkg::knot_val(k, IN_W, SEG_W, OUT_W);
    localparam longint KHI = plf_pkg::knot_val(k + 1, IN_W, SEG_W, OUT_W);
    assign base_tab[k]  = OUT_W'(KLO);
    assign slope_tab[k] = SLOPE_W'(KHI - KLO);
  end

  logic [SEG_W-1:0] idx;
  assign idx = x_i[IN_W-1:FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else if (en) vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      base_o  <= base_tab[idx];
      slope_o <= slope_tab[idx];
      frac_o  <= x_i[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/plf_interp_mac.sv
module plf_interp_mac #(
  parameter int OUT_W   = 10,
  parameter int SLOPE_W = 7,
  parameter int FRAC_W  = 5,
  localparam int PROD_W = SLOPE_W + FRAC_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               vld_i,
  input  logic [OUT_W-1:0]   base_i,
  input  logic [SLOPE_W-1:0] slope_i,
  input  logic [FRAC_W-1:0]  frac_i,
  output logic               vld_o,
  output logic [OUT_W-1:0]   base_o,
  output logic [PROD_W-1:0]  prod_o
);
  localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);

  logic [PROD_W-1:0] prod_c;
  assign prod_c = PROD_W'(slope_i) * PROD_W'(frac_i) + HALF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else if (en) vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      base_o <= base_i;
      prod_o <= prod_c;
    end
  end
endmodule

// File: rtl/plf_round_sat.sv
module plf_round_sat #(
  parameter int OUT_W  = 10,
  parameter int FRAC_W = 5,
  parameter int PROD_W = 13,
  localparam int SUM_W = (OUT_W > PROD_W ? OUT_W : PROD_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              vld_i,
  input  logic [OUT_W-1:0]  base_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic              vld_o,
  output logic [OUT_W-1:0]  res_o
);
  localparam logic [SUM_W-1:0] TOP = SUM_W'((longint'(1) << OUT_W) - 1);

  logic [SUM_W-1:0] sum_c;
  logic [OUT_W-1:0] sat_c;

  assign sum_c = SUM_W'(base_i) + SUM_W'(prod_i >> FRAC_W);
  assign sat_c = (sum_c > TOP) ? OUT_W'(TOP) : sum_c[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else if (en) vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    if (en) res_o <= sat_c;
  end
endmodule

// File: rtl/plf_eval.sv
module plf_eval #(
  parameter int IN_W    = 10,
  parameter int SEG_W   = 5,
  parameter int OUT_W   = 10,
  parameter int SLOPE_W = 7,
  localparam int FRAC_W = IN_W - SEG_W,
  localparam int PROD_W = SLOPE_W + FRAC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arg_valid,
  output logic             arg_ready,
  input  logic [IN_W-1:0]  arg_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [OUT_W-1:0] res_data
);
  logic               adv;
  logic               v1, v2, v3;
  logic [IN_W-1:0]    x1;
  logic [OUT_W-1:0]   base2, base3;
  logic [SLOPE_W-1:0] slope2;
  logic [FRAC_W-1:0]  frac2;
  logic [PROD_W-1:0]  prod3;

  // Whole pipeline steps together when the output slot frees up.
  assign adv       = !res_valid || res_ready;
  assign arg_ready = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1 <= 1'b0;
    else if (adv) v1 <= arg_valid;
  end

  always_ff @(posedge clk) begin
    if (adv) x1 <= arg_data;
  end

  plf_seg_rom #(.IN_W(IN_W), .SEG_W(SEG_W), .OUT_W(OUT_W), .SLOPE_W(SLOPE_W)) u_rom (
    .clk(clk), .rst_n(rst_n), .en(adv), .vld_i(v1), .x_i(x1),
    .vld_o(v2), .base_o(base2), .slope_o(slope2), .frac_o(frac2)
  );

  plf_interp_mac #(.OUT_W(OUT_W), .SLOPE_W(SLOPE_W), .FRAC_W(FRAC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(adv), .vld_i(v2), .base_i(base2),
    .slope_i(slope2), .frac_i(frac2),
    .vld_o(v3), .base_o(base3), .prod_o(prod3)
  );

  plf_round_sat #(.OUT_W(OUT_W), .FRAC_W(FRAC_W), .PROD_W(PROD_W)) u_sat (
    .clk(clk), .rst_n(rst_n), .en(adv), .vld_i(v3), .base_i(base3),
    .prod_i(prod3), .vld_o(res_valid), .res_o(res_data)
  );
endmodule

// File: rtl/plf_eval_chk.sv
module plf_eval_chk #(
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arg_valid,
  input logic             arg_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [OUT_W-1:0] res_data
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !res_valid); // R1

  AST_FOUR_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (arg_valid && arg_ready) ##1 arg_ready ##1 arg_ready ##1 arg_ready
    |=> res_valid); // R4

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (!arg_valid && arg_ready) ##1 arg_ready ##1 arg_ready ##1 arg_ready
    |=> !res_valid); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data))); // R7

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !arg_ready); // R7
endmodule

bind plf_eval plf_eval_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arg_valid(arg_valid), .arg_ready(arg_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
);

// File: tb/plf_eval_bench.sv
module plf_eval_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arg_valid = 1'b0;
  logic       arg_ready;
  logic [9:0] arg_data = '0;
  logic       res_valid;
  logic       res_ready = 1'b1;
  logic [9:0] res_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  int exp_q[$];
  int x_q[$];
  int cyc_q[$];
  int lat_q[$];

  always #10 clk = ~clk;

  plf_eval u_plf_eval (
    .clk(clk), .rst_n(rst_n), .arg_valid(arg_valid), .arg_ready(arg_ready),
    .arg_data(arg_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model(input int x);
    int k, f, v;
    k = x >> 5;
    f = x & 31;
    v = k * (64 - k) + (((63 - 2 * k) * f + 16) >> 5);
    if (v > 1023) v = 1023;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // res_ready driver: always ready, or pseudo-random stalls
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rdy_mode == 0) res_ready <= 1'b1;
    else res_ready <= lfsr[0] | lfsr[3];
  end

  task automatic send(input int x);
    @(negedge clk);
    arg_valid = 1'b1;
    arg_data  = 10'(x);
    #1;
    while (!arg_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(x));
    x_q.push_back(x);
    cyc_q.push_back(cyc);
    lat_q.push_back(rdy_mode == 0 ? 1 : 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      arg_valid = 1'b0;
    end
  endtask

  // Scoreboard monitor
  initial begin
    bit   prev_stall = 1'b0;
    logic [9:0] prev_data = '0;
    forever begin
      @(negedge clk);
      #2;
      if (!rst_n) continue;
      if (prev_stall)
        check(res_valid && res_data == prev_data, "R7 stalled result held",
              int'(res_data), int'(prev_data));
      if (res_valid && !res_ready)
        check(!arg_ready, "R7 arg_ready low in stall", int'(arg_ready), 0);
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected result", int'(res_data), -1);
        end else begin
          int e, x, c, l;
          real ex, d;
          e = exp_q.pop_front();
          x = x_q.pop_front();
          c = cyc_q.pop_front();
          l = lat_q.pop_front();
          if (x >= 1008) check(res_data == 10'd1023, "R6 saturation", int'(res_data), 1023);
          else if ((x & 31) == 0) check(int'(res_data) == e, "R8 knot exact", int'(res_data), e);
          else check(int'(res_data) == e, "R2 interpolation", int'(res_data), e);
          ex = real'(x) * (2048.0 - real'(x)) / 1024.0;
          d  = real'(res_data) - ex;
          if (d < 0.0) d = -d;
          check(d < 1.0, "R3 error below 1 LSB", int'(res_data), int'(ex));
          if (l == 1) check(cyc - c == 4, "R4 latency", cyc - c, 4);
        end
      end
      prev_stall = res_valid && !res_ready;
      prev_data  = res_data;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(!res_valid, "R1 res_valid low in reset", int'(res_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(arg_ready, "R1 arg_ready after reset", int'(arg_ready), 1);
    check(!res_valid, "R1 res_valid after reset", int'(res_valid), 0);

    // R5: full sweep back-to-back, always ready
    for (int x = 0; x < 1024; x++) begin
      send(x);
      check(arg_ready, "R5 accepts every cycle", int'(arg_ready), 1);
    end
    idle(8);
    check(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 0);

    // sparse pattern with bubbles, always ready (R4, R8)
    for (int k = 0; k < 32; k++) begin
      send(k * 32);
      idle(k % 3);
    end
    idle(8);

    // stalls combined with saturating and knot arguments (R6, R7)
    rdy_mode = 1;
    for (int r = 0; r < 6; r++) begin
      for (int x = 1000; x < 1024; x++) send(x);
      for (int k = 0; k < 32; k += 5) send(k * 32);
      for (int i = 0; i < 40; i++) begin
        send((i * 397 + r * 131) % 1024);
        if (i % 7 == 0) idle(2);
      end
    end
    idle(1);
    rdy_mode = 0;
    idle(12);
    check(exp_q.size() == 0, "R7 no result lost", exp_q.size(), 0);
    finish_run();
  end
endmodule